// File: doc/BRIEF.md
# Sector Read Address Sequencer

This block produces the byte addresses for streaming reads from a small protected array. The array holds fourteen sectors of eight bytes each, 112 bytes in total. The command decoder gives the block a sector number and a start strobe once the host's password has been accepted. The block then points the array at byte 0 of that sector and moves forward by one byte each time the host acknowledges a byte it received. The byte-level access path has no random access. A read always begins on a sector boundary, runs on through the following sectors, and goes back to the start of the array after its last byte.

The serial engine reports the end of every byte on `byte_done_i`, and `host_ack_i` carries the host's response. An acknowledged byte moves the address forward. A withheld acknowledge freezes the sequencer until a stop condition sends it back to idle. If chip select drops, the read is abandoned at once. The block does not check passwords and does not shift bits. It only takes the password result as an input.

Top module: `sector_read_seq`

## Requirements
- R1: After reset, `rd_valid_o`, `cmd_ack_o` and `cmd_nack_o` are 0 and `rd_addr_o` is 0.
- R2: In idle, a start with `sel_i`=1, `pw_ok_i`=1 and a sector number below 14 gives the following on the next cycle: `cmd_ack_o`=1 for exactly one cycle, `rd_valid_o`=1, and `rd_addr_o` = sector × 8.
- R3: A start that gives sector number 14 or 15 raises `cmd_nack_o` for one cycle on the next cycle. No read begins, so `rd_valid_o` stays 0.
- R4: A start with `pw_ok_i`=0 raises `cmd_nack_o` on the next cycle and does not begin a read, whatever the sector number.
- R5: While streaming, a `byte_done_i` pulse with `host_ack_i`=1 adds 1 to `rd_addr_o` on the next cycle. This also carries from byte 7 of one sector into byte 0 of the next sector.
- R6: An acknowledged byte at address 111 wraps `rd_addr_o` to 0. `rd_addr_o` never reaches 112 or higher.
- R7: While streaming, a `byte_done_i` pulse with `host_ack_i`=0 clears `rd_valid_o` on the next cycle and holds `rd_addr_o`. After that, byte pulses and start strobes have no effect until a stop arrives.
- R8: `stop_i` with `sel_i`=1 during a read or a frozen read returns the block to idle on the next cycle: `rd_valid_o`=0 and `rd_addr_o`=0. A new start is accepted after that.
- R9: `sel_i`=0 overrides every other input. On the next cycle `rd_valid_o`=0, `rd_addr_o`=0 and no command response is raised.
- R10: A start strobe during a read is ignored. The address is left unchanged and neither `cmd_ack_o` nor `cmd_nack_o` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Chip select, active high; low aborts any read |
| start_i | input | 1 | One-cycle read command strobe |
| sector_i | input | 4 | Sector number carried with the command |
| pw_ok_i | input | 1 | Password has been accepted |
| byte_done_i | input | 1 | One-cycle pulse at the end of each byte transfer |
| host_ack_i | input | 1 | Host response to that byte: 1 = ACK, 0 = NACK |
| stop_i | input | 1 | One-cycle stop condition strobe |
| rd_addr_o | output | 7 | Byte address to the array |
| rd_valid_o | output | 1 | Address is live for an active read |
| cmd_ack_o | output | 1 | One-cycle pulse: command accepted |
| cmd_nack_o | output | 1 | One-cycle pulse: command rejected |

## Verification
The hardest case to reach is the wrap from address 111 to 0. It only happens after a read has run through the whole of the last sector. The stimulus starts at sector 13 and sends eight acknowledged bytes. It checks the address after each one, so both the carry at the sector edge and the return to 0 are seen. The frozen state after a NACK is also hard to observe, because it looks like idle from outside. The bench therefore sends acknowledged bytes and a start while frozen. It checks that the address is held and that no command response appears, and only then sends the stop.

// File: rtl/sector_seq_pkg.sv
package sector_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_STREAM = 2'd1,
    SQ_HALT   = 2'd2
  } sq_state_t;

  // first byte address of a sector
  function automatic logic [15:0] base_of(input logic [15:0] sec, input logic [15:0] bps);
    return sec * bps;
  endfunction

  // next byte address, wrapping at the end of the array
  function automatic logic [15:0] step_of(input logic [15:0] a, input logic [15:0] total);
    return (a == total - 16'd1) ? 16'd0 : a + 16'd1;
  endfunction
endpackage

// File: rtl/sq_cmd_check.sv
module sq_cmd_check #(
  parameter int NUM_SECTORS = 14,
  parameter int SEC_W       = 4
) (
  input  logic             in_idle,
  input  logic             sel_i,
  input  logic             start_i,
  input  logic             pw_ok_i,
  input  logic [SEC_W-1:0] sector_i,
  output logic             start_ok,
  output logic             start_bad
);
  logic sector_in_range;
  logic cmd_seen;

  assign sector_in_range = 32'(sector_i) < NUM_SECTORS;
  assign cmd_seen        = in_idle && sel_i && start_i;
  assign start_ok        = cmd_seen && pw_ok_i && sector_in_range;
  assign start_bad       = cmd_seen && !(pw_ok_i && sector_in_range);
endmodule

// File: rtl/sq_addr_counter.sv
module sq_addr_counter
  import sector_seq_pkg::*;
#(
  parameter int BYTES_PER_SECTOR = 8,
  parameter int TOTAL_BYTES      = 112,
  parameter int SEC_W            = 4,
  parameter int ADDR_W           = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [SEC_W-1:0]  load_sector,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr,
  output logic              wrap_evt
);
  logic [15:0] base_full;
  logic [15:0] step_full;

  assign base_full = base_of(16'(load_sector), 16'(BYTES_PER_SECTOR));
  assign step_full = step_of(16'(addr), 16'(TOTAL_BYTES));
  assign wrap_evt  = adv && (step_full == 16'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr <= '0;
    else if (clear) addr <= '0;
    else if (load)  addr <= base_full[ADDR_W-1:0];
    else if (adv)   addr <= step_full[ADDR_W-1:0];
  end
endmodule

// File: rtl/sq_fsm.sv
module sq_fsm
  import sector_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sel_i,
  input  logic      stop_i,
  input  logic      start_ok,
  input  logic      beat_nack,
  output sq_state_t state
);
  sq_state_t state_nxt;

  always_comb begin
    state_nxt = state;
    if (!sel_i) state_nxt = SQ_IDLE;
    else begin
      case (state)
        SQ_IDLE:   if (start_ok) state_nxt = SQ_STREAM;
        SQ_STREAM: if (stop_i) state_nxt = SQ_IDLE;
                   else if (beat_nack) state_nxt = SQ_HALT;
        SQ_HALT:   if (stop_i) state_nxt = SQ_IDLE;
        default:   state_nxt = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SQ_IDLE;
    else        state <= state_nxt;
  end
endmodule

// File: rtl/sector_read_seq.sv
module sector_read_seq
  import sector_seq_pkg::*;
#(
  parameter int NUM_SECTORS      = 14,
  parameter int BYTES_PER_SECTOR = 8,
  localparam int TOTAL_BYTES     = NUM_SECTORS * BYTES_PER_SECTOR,
  localparam int SEC_W           = $clog2(NUM_SECTORS),
  localparam int ADDR_W          = $clog2(TOTAL_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              start_i,
  input  logic [SEC_W-1:0]  sector_i,
  input  logic              pw_ok_i,
  input  logic              byte_done_i,
  input  logic              host_ack_i,
  input  logic              stop_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rd_valid_o,
  output logic              cmd_ack_o,
  output logic              cmd_nack_o
);
  sq_state_t state;
  logic in_idle, streaming;
  logic start_ok, start_bad;
  logic beat_live, adv, halt_evt, wrap_evt, clear;

  assign in_idle   = (state == SQ_IDLE);
  assign streaming = (state == SQ_STREAM);
  assign beat_live = streaming && sel_i && !stop_i && byte_done_i;
  assign adv       = beat_live && host_ack_i;
  assign halt_evt  = beat_live && !host_ack_i;
  assign clear     = !sel_i || (stop_i && !in_idle);

  sq_cmd_check #(.NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W)) u_cmd (
    .in_idle(in_idle), .sel_i(sel_i), .start_i(start_i), .pw_ok_i(pw_ok_i),
    .sector_i(sector_i), .start_ok(start_ok), .start_bad(start_bad)
  );

  sq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .stop_i(stop_i),
    .start_ok(start_ok), .beat_nack(halt_evt), .state(state)
  );

  sq_addr_counter #(
    .BYTES_PER_SECTOR(BYTES_PER_SECTOR), .TOTAL_BYTES(TOTAL_BYTES),
    .SEC_W(SEC_W), .ADDR_W(ADDR_W)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .clear(clear), .load(start_ok),
    .load_sector(sector_i), .adv(adv), .addr(rd_addr_o), .wrap_evt(wrap_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_ack_o  <= 1'b0;
      cmd_nack_o <= 1'b0;
    end else begin
      cmd_ack_o  <= start_ok;
      cmd_nack_o <= start_bad;
    end
  end

  assign rd_valid_o = streaming;
endmodule

// File: rtl/sector_read_seq_chk.sv
module sector_read_seq_chk #(
  parameter int NUM_SECTORS      = 14,
  parameter int BYTES_PER_SECTOR = 8,
  parameter int SEC_W            = 4,
  parameter int ADDR_W           = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_i,
  input logic              stop_i,
  input logic [SEC_W-1:0]  sector_i,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_valid_o,
  input logic              cmd_ack_o,
  input logic              cmd_nack_o,
  input logic              start_ok,
  input logic              start_bad,
  input logic              adv,
  input logic              halt_evt
);
  localparam int TOTAL = NUM_SECTORS * BYTES_PER_SECTOR;

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> rd_valid_o && cmd_ack_o &&
      (32'(rd_addr_o) == 32'($past(sector_i)) * BYTES_PER_SECTOR)); // R2
  AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ack_o && cmd_nack_o)); // R2
  AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> cmd_nack_o && !rd_valid_o); // R3
  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> rd_valid_o && (32'(rd_addr_o) ==
      ((32'($past(rd_addr_o)) == TOTAL - 1) ? 0 : 32'($past(rd_addr_o)) + 1))); // R5
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rd_addr_o) < TOTAL); // R6
  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_evt |=> !rd_valid_o && $stable(rd_addr_o)); // R7
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && sel_i) |=> !rd_valid_o); // R8
  AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> !rd_valid_o && rd_addr_o == '0 && !cmd_ack_o && !cmd_nack_o); // R9
endmodule

bind sector_read_seq sector_read_seq_chk #(
  .NUM_SECTORS(NUM_SECTORS), .BYTES_PER_SECTOR(BYTES_PER_SECTOR),
  .SEC_W(SEC_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .stop_i(stop_i), .sector_i(sector_i),
  .rd_addr_o(rd_addr_o), .rd_valid_o(rd_valid_o), .cmd_ack_o(cmd_ack_o),
  .cmd_nack_o(cmd_nack_o), .start_ok(start_ok), .start_bad(start_bad),
  .adv(adv), .halt_evt(halt_evt)
);

// File: tb/sector_read_seq_tb.sv
module sector_read_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, start = 1'b0, pw = 1'b0, bdone = 1'b0, hack = 1'b0, stop = 1'b0;
  logic [3:0] sector = '0;
  logic [6:0] addr;
  logic valid, rack, rnack;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sector_read_seq u_dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .start_i(start), .sector_i(sector),
    .pw_ok_i(pw), .byte_done_i(bdone), .host_ack_i(hack), .stop_i(stop),
    .rd_addr_o(addr), .rd_valid_o(valid), .cmd_ack_o(rack), .cmd_nack_o(rnack)
  );

  // {sector[3:0], password ok, expect accepted}
  localparam logic [5:0] VEC [0:7] = '{
    {4'd0, 1'b1, 1'b1}, {4'd5, 1'b1, 1'b1}, {4'd14, 1'b1, 1'b0}, {4'd13, 1'b1, 1'b1},
    {4'd3, 1'b0, 1'b0}, {4'd15, 1'b1, 1'b0}, {4'd1, 1'b1, 1'b1}, {4'd9, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_start(input logic [3:0] s, input logic p);
    @(negedge clk); start = 1'b1; sector = s; pw = p;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic do_beat(input logic a);
    @(negedge clk); bdone = 1'b1; hack = a;
    @(negedge clk); bdone = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(valid == 0 && rack == 0 && rnack == 0, "R1 outputs idle", {valid, rack, rnack}, 0);
    chk(addr == 0, "R1 address zero", addr, 0);
    rst_n = 1'b1; sel = 1'b1;

    // table walk: R2 / R3 / R4
    for (int i = 0; i < 8; i++) begin
      logic [3:0] s; logic p, e;
      {s, p, e} = VEC[i];
      do_start(s, p);
      if (e) begin
        chk(rack == 1 && rnack == 0 && valid == 1, "R2 accepted", {rack, rnack, valid}, 5);
        chk(addr == 7'(s * 8), "R2 start address", addr, s * 8);
        @(negedge clk);
        chk(rack == 0, "R2 ack one cycle", rack, 0);
        do_stop();
      end else begin
        chk(rnack == 1 && rack == 0, p ? "R3 range reject" : "R4 password reject",
            {rnack, rack}, 2);
        chk(valid == 0, p ? "R3 no read" : "R4 no read", valid, 0);
        @(negedge clk);
        chk(rnack == 0, "R3 nack one cycle", rnack, 0);
      end
    end

    // R5 sector crossing
    do_start(4'd2, 1'b1);
    for (int k = 1; k <= 8; k++) begin
      do_beat(1'b1);
      chk(addr == 7'(16 + k) && valid, "R5 step", addr, 16 + k);
    end
    // R10 start while streaming ignored
    do_start(4'd7, 1'b1);
    chk(addr == 24 && rack == 0 && rnack == 0, "R10 start ignored", addr, 24);
    // R8 stop returns to idle
    do_stop();
    chk(valid == 0 && addr == 0, "R8 stop to idle", {valid, addr}, 0);

    // R6 wrap from last byte
    do_start(4'd13, 1'b1);
    for (int k = 1; k <= 7; k++) begin
      do_beat(1'b1);
      chk(addr == 7'(104 + k), "R6 last sector step", addr, 104 + k);
    end
    do_beat(1'b1);
    chk(addr == 0 && valid, "R6 wrap to zero", addr, 0);
    do_beat(1'b1);
    chk(addr == 1, "R6 continue after wrap", addr, 1);

    // R7 NACK freezes
    do_beat(1'b0);
    chk(valid == 0 && addr == 1, "R7 freeze", {valid, addr}, 1);
    do_beat(1'b1);
    chk(addr == 1 && valid == 0, "R7 beat ignored", addr, 1);
    do_start(4'd4, 1'b1);
    chk(rack == 0 && rnack == 0 && addr == 1, "R7 start ignored", addr, 1);
    do_stop();
    chk(addr == 0 && valid == 0, "R8 stop after nack", addr, 0);
    do_start(4'd6, 1'b1);
    chk(rack && valid && addr == 48, "R8 restart", addr, 48);

    // R9 deselect aborts
    do_beat(1'b1);
    @(negedge clk); sel = 1'b0;
    @(negedge clk);
    chk(valid == 0 && addr == 0, "R9 abort", {valid, addr}, 0);
    do_start(4'd3, 1'b1);
    chk(rack == 0 && rnack == 0 && valid == 0, "R9 start while deselected", {rack, rnack, valid}, 0);
    sel = 1'b1;
    do_start(4'd3, 1'b1);
    chk(valid && addr == 24, "R9 reselect works", addr, 24);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule